// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block sits between a simple host port and a four-bank synchronous DRAM with a 16-bit data path. The host presents one word access at a time with a valid/ready handshake: a flat word address, a write flag and the write data. The controller turns each access into the pin-level commands the memory needs. Read data comes back on a separate port, marked by a one-cycle valid strobe.

After reset the controller waits out a settle delay. It then precharges every bank, issues a number of auto-refresh commands and programs the mode register. The burst length is one word and the CAS latency comes from a parameter. In normal operation it keeps one row open in each bank and looks up the bank's open-row register on every request. A request to the open row goes straight to a column command. A request to another row first precharges that bank and then activates the new row. A request to a closed bank activates it.

A refresh interval timer is derived from the clock-frequency parameter. When it expires, the controller finishes the access in flight, closes all open banks, issues an auto-refresh and forgets every open row. Every pin change comes from a register, so the pins are stable at the rising edge where the memory samples them.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and through the whole settle delay after it, the command pins show NOP, `req_ready` is low and `rd_valid` is low.
- R2: After reset the pins show NOP for at least INIT_US*CLK_MHZ cycles. The controller then issues a precharge with A10=1, at least INIT_REFS (default 2) auto-refreshes, and a mode load with A[2:0]=000 (burst length 1), A3=0 (sequential), A[6:4]=CAS_LAT and all other address bits 0. Only after all of that is a request accepted.
- R3: Commands are encoded on {cs_n,ras_n,cas_n,we_n}: mode load 0000, auto-refresh 0001, precharge 0010, activate 0011, write 0100, read 0101, NOP 0111. Every cycle without a command shows NOP.
- R4: `req_addr[23:22]` selects the bank, `[21:9]` the row and `[8:0]` the column. A read or write carries the column on A[8:0] with A10=0, and targets a bank whose open row equals the requested row.
- R5: A request to a bank's open row issues no activate. A request to a different row of an open bank issues a precharge of that bank only (A10=0) and then an activate. A request to a closed bank issues only an activate.
- R6: Read or write comes at least T_RCD cycles after the activate of its bank. Activate or refresh comes at least T_RP cycles after a precharge. Any command comes at least T_RFC cycles after a refresh, and at least T_MRD cycles after the mode load.
- R7: A precharge comes at least T_WR cycles after the last write command.
- R8: After initialization, consecutive auto-refreshes are never more than REFI_NS*CLK_MHZ/1000 cycles apart, including while requests keep arriving. A pending refresh holds `req_ready` low.
- R9: An auto-refresh is issued only when every bank is closed; the controller precharges all banks (A10=1) first if any is open. After the refresh, the first access to any bank issues an activate.
- R10: For each read command sampled at edge E, `rd_valid` is high for exactly one cycle after edge E+CAS_LAT, and `rd_data` equals the value on `sd_dq_in` at that edge.
- R11: In the cycle a write command is on the pins, `sd_dq_oe` is 1, `sd_dq_out` holds the request's write data and `sd_dqm` is 00. In every other cycle `sd_dq_oe` is 0.
- R12: A request is accepted on a clock edge with `req_valid` and `req_ready` both high. Each accepted request produces exactly one read or write command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the memory |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller accepts a request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address {bank, row, column} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 16 | Returned read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Row / column / mode address |
| sd_dqm | output | 2 | Byte data masks |
| sd_dq_out | output | 16 | Data driven toward the memory |
| sd_dq_oe | output | 1 | Output enable for `sd_dq_out` |
| sd_dq_in | input | 16 | Data returned from the memory |

## Verification
The refresh deadline and a waiting host request can both come due in the same idle cycle. In that case the refresh must win while the request stays pending and is served afterwards. A long stream of alternating writes and reads spread over every bank, with frequent row changes, runs across several refresh intervals so that this collision happens. The behavioural memory in the bench checks each command against the bank states and the timing windows, and it checks the spacing between refreshes. Every read in the stream must return the word the stream last wrote there.

// File: rtl/sdc_pkg.sv
// Shared encodings for the SDRAM command sequencing controller.
// Assumes the memory decodes {cs_n, ras_n, cas_n, we_n} on its rising clock edge.
package sdc_pkg;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111,
        CMD_INH = 4'b1000
    } sd_cmd_e;

    typedef enum logic [3:0] {
        S_SETTLE,
        S_INIT_PRE,
        S_INIT_REF,
        S_INIT_LMR,
        S_IDLE,
        S_MISS_PRE,
        S_ACT,
        S_RW,
        S_REF_PRE,
        S_REF_AR,
        S_WAIT
    } seq_state_e;

endpackage

// File: rtl/sdc_refresh_timer.sv
// Refresh interval timer: raises 'due' LIMIT cycles after it is enabled or
// acknowledged, and holds it until the next acknowledge.
// Assumes 'ack' is pulsed in the cycle the auto-refresh command is issued.
module sdc_refresh_timer #(
    parameter int LIMIT = 748
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic ack,
    output logic due
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count enabled cycles since the last refresh and flag the deadline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            due <= 1'b0;
        end else if (!en || ack) begin
            cnt <= '0;
            due <= 1'b0;
        end else if (!due) begin
            if (cnt == CW'(LIMIT - 1)) begin
                due <= 1'b1;
            end
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sdc_open_rows.sv
// Per-bank open-row registers with a row-hit lookup.
// Assumes a close and a set are never requested for the same bank together.
module sdc_open_rows #(
    parameter int BANKS = 4,
    parameter int ROW_W = 13
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(BANKS)-1:0]   q_bank,
    input  logic [ROW_W-1:0]           q_row,
    output logic                       q_open,
    output logic                       q_hit,
    output logic                       any_open,
    input  logic                       set_en,
    input  logic                       close_en,
    input  logic                       close_all,
    input  logic [$clog2(BANKS)-1:0]   upd_bank,
    input  logic [ROW_W-1:0]           upd_row
);
    localparam int BW = $clog2(BANKS);

    logic [BANKS-1:0] open_v;
    logic [ROW_W-1:0] open_row [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        // Track whether bank g has a row open and which one.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_v[g] <= 1'b0;
            end else if (close_all || (close_en && upd_bank == BW'(g))) begin
                open_v[g] <= 1'b0;
            end else if (set_en && upd_bank == BW'(g)) begin
                open_v[g]   <= 1'b1;
                open_row[g] <= upd_row;
            end
        end
    end

    // Lookup of the queried bank.
    always_comb begin
        q_open   = open_v[q_bank];
        q_hit    = open_v[q_bank] && (open_row[q_bank] == q_row);
        any_open = |open_v;
    end

endmodule

// File: rtl/sdc_read_pipe.sv
// Read return pipe: captures memory data CAS_LAT edges after the edge that
// samples a read command and marks it with a one-cycle valid.
// Assumes CAS_LAT is 2 or 3 and 'issue' is high while a read is on the pins.
module sdc_read_pipe #(
    parameter int CAS_LAT = 2,
    parameter int DW      = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic [DW-1:0] dq_in,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data
);
    logic [CAS_LAT-1:0] stage;

    // Delay the read marker and capture data when it reaches the last stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            stage    <= {stage[CAS_LAT-2:0], issue};
            rd_valid <= stage[CAS_LAT-1];
            if (stage[CAS_LAT-1]) begin
                rd_data <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sdram_seq_ctrl.sv
// SDRAM command sequencing controller: power-up initialization, mode load,
// open-row-per-bank access, write recovery and periodic auto-refresh.
// Assumes COL_W <= 10 (A10 is the precharge-all / auto-precharge flag),
// burst length 1, and that the memory shares 'clk'. All pins are registered.
module sdram_seq_ctrl #(
    parameter int CLK_MHZ   = 100,
    parameter int INIT_US   = 100,
    parameter int REFI_NS   = 7800,
    parameter int CAS_LAT   = 2,
    parameter int T_RCD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RFC     = 7,
    parameter int T_WR      = 2,
    parameter int T_MRD     = 2,
    parameter int INIT_REFS = 2,
    parameter int DW        = 16,
    parameter int BA_W      = 2,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic                         req_we,
    input  logic [BA_W+ROW_W+COL_W-1:0]  req_addr,
    input  logic [DW-1:0]                req_wdata,
    output logic                         rd_valid,
    output logic [DW-1:0]                rd_data,
    output logic                         sd_cs_n,
    output logic                         sd_ras_n,
    output logic                         sd_cas_n,
    output logic                         sd_we_n,
    output logic [BA_W-1:0]              sd_ba,
    output logic [ROW_W-1:0]             sd_a,
    output logic [DW/8-1:0]              sd_dqm,
    output logic [DW-1:0]                sd_dq_out,
    output logic                         sd_dq_oe,
    input  logic [DW-1:0]                sd_dq_in
);
    import sdc_pkg::*;

    localparam int ADDR_W    = BA_W + ROW_W + COL_W;
    localparam int BANKS     = 1 << BA_W;
    localparam int INIT_CYC  = INIT_US * CLK_MHZ;
    localparam int REFI_CYC  = (REFI_NS * CLK_MHZ) / 1000;
    localparam int REF_SLACK = 32;
    localparam int REF_LIMIT = REFI_CYC - REF_SLACK;
    localparam int SCW       = $clog2(INIT_CYC + 1);
    localparam int WCW       = $clog2(T_RFC + T_RP + T_RCD + T_MRD + CAS_LAT + 4);
    localparam int WRW       = $clog2(T_WR + 1);
    localparam int NRW       = $clog2(INIT_REFS + 1);
    // Wait-state counts: a command issued at edge k is followed by the next
    // one no earlier than edge k + max(n, 2).
    localparam int W_RP      = (T_RP > 2) ? T_RP - 2 : 0;
    localparam int W_RCD     = (T_RCD > 2) ? T_RCD - 2 : 0;
    localparam int W_RFC     = (T_RFC > 2) ? T_RFC - 2 : 0;
    localparam int W_MRD     = (T_MRD > 2) ? T_MRD - 2 : 0;
    localparam int W_RD      = CAS_LAT - 1;
    localparam logic [ROW_W-1:0] A_ALL     = ROW_W'(1 << 10);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    seq_state_e           state, ret;
    sd_cmd_e              cmd_q;
    logic [SCW-1:0]       settle;
    logic [WCW-1:0]       wcnt;
    logic [WRW-1:0]       wr_rec;
    logic [NRW-1:0]       nref;
    logic                 init_done;
    logic                 lat_we;
    logic [BA_W-1:0]      lat_bank;
    logic [ROW_W-1:0]     lat_row;
    logic [COL_W-1:0]     lat_col;
    logic [DW-1:0]        lat_wdata;

    logic [BA_W-1:0]      rq_bank;
    logic [ROW_W-1:0]     rq_row;
    logic                 q_open, q_hit, any_open;
    logic                 set_en, close_en, close_all;
    logic                 ref_due, ref_ack;

    // Split the host address into bank, row and column fields.
    always_comb begin
        rq_bank = req_addr[ADDR_W-1 -: BA_W];
        rq_row  = req_addr[COL_W +: ROW_W];
    end

    // Open-row register updates and refresh handshake derived from the state.
    always_comb begin
        set_en    = (state == S_ACT);
        close_en  = (state == S_MISS_PRE) && (wr_rec == '0);
        close_all = ((state == S_REF_PRE) && any_open && (wr_rec == '0))
                    || (state == S_REF_AR);
        ref_ack   = (state == S_REF_AR);
        req_ready = (state == S_IDLE) && !ref_due;
    end

    sdc_open_rows #(
        .BANKS (BANKS),
        .ROW_W (ROW_W)
    ) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .q_bank    (rq_bank),
        .q_row     (rq_row),
        .q_open    (q_open),
        .q_hit     (q_hit),
        .any_open  (any_open),
        .set_en    (set_en),
        .close_en  (close_en),
        .close_all (close_all),
        .upd_bank  (lat_bank),
        .upd_row   (lat_row)
    );

    sdc_refresh_timer #(
        .LIMIT (REF_LIMIT)
    ) u_refi (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (init_done),
        .ack   (ref_ack),
        .due   (ref_due)
    );

    sdc_read_pipe #(
        .CAS_LAT (CAS_LAT),
        .DW      (DW)
    ) u_rdp (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (cmd_q == CMD_RD),
        .dq_in    (sd_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Drive the command pins from the registered command.
    always_comb begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    end

    // Main sequencer: walks init, access and refresh states and registers pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_SETTLE;
            ret       <= S_IDLE;
            cmd_q     <= CMD_NOP;
            sd_ba     <= '0;
            sd_a      <= '0;
            sd_dqm    <= '1;
            sd_dq_out <= '0;
            sd_dq_oe  <= 1'b0;
            settle    <= '0;
            wcnt      <= '0;
            wr_rec    <= '0;
            nref      <= '0;
            init_done <= 1'b0;
            lat_we    <= 1'b0;
            lat_bank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
            lat_wdata <= '0;
        end else begin
            cmd_q    <= CMD_NOP;
            sd_dq_oe <= 1'b0;
            if (wr_rec != '0) begin
                wr_rec <= wr_rec - 1'b1;
            end
            case (state)
                S_SETTLE: begin
                    if (settle == SCW'(INIT_CYC - 1)) begin
                        state <= S_INIT_PRE;
                    end else begin
                        settle <= settle + 1'b1;
                    end
                end
                S_INIT_PRE: begin
                    cmd_q <= CMD_PRE;
                    sd_a  <= A_ALL;
                    wcnt  <= WCW'(W_RP);
                    ret   <= S_INIT_REF;
                    state <= S_WAIT;
                end
                S_INIT_REF: begin
                    cmd_q <= CMD_REF;
                    nref  <= nref + 1'b1;
                    wcnt  <= WCW'(W_RFC);
                    ret   <= (nref == NRW'(INIT_REFS - 1)) ? S_INIT_LMR : S_INIT_REF;
                    state <= S_WAIT;
                end
                S_INIT_LMR: begin
                    cmd_q     <= CMD_LMR;
                    sd_ba     <= '0;
                    sd_a      <= MODE_WORD;
                    sd_dqm    <= '0;
                    init_done <= 1'b1;
                    wcnt      <= WCW'(W_MRD);
                    ret       <= S_IDLE;
                    state     <= S_WAIT;
                end
                S_WAIT: begin
                    if (wcnt == '0) begin
                        state <= ret;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                S_IDLE: begin
                    if (ref_due) begin
                        state <= S_REF_PRE;
                    end else if (req_valid) begin
                        lat_we    <= req_we;
                        lat_bank  <= rq_bank;
                        lat_row   <= rq_row;
                        lat_col   <= req_addr[COL_W-1:0];
                        lat_wdata <= req_wdata;
                        if (q_hit) begin
                            state <= S_RW;
                        end else if (q_open) begin
                            state <= S_MISS_PRE;
                        end else begin
                            state <= S_ACT;
                        end
                    end
                end
                S_MISS_PRE: begin
                    if (wr_rec == '0) begin
                        cmd_q <= CMD_PRE;
                        sd_ba <= lat_bank;
                        sd_a  <= '0;
                        wcnt  <= WCW'(W_RP);
                        ret   <= S_ACT;
                        state <= S_WAIT;
                    end
                end
                S_ACT: begin
                    cmd_q <= CMD_ACT;
                    sd_ba <= lat_bank;
                    sd_a  <= lat_row;
                    wcnt  <= WCW'(W_RCD);
                    ret   <= S_RW;
                    state <= S_WAIT;
                end
                S_RW: begin
                    sd_ba <= lat_bank;
                    sd_a  <= ROW_W'(lat_col);
                    if (lat_we) begin
                        cmd_q     <= CMD_WR;
                        sd_dq_oe  <= 1'b1;
                        sd_dq_out <= lat_wdata;
                        wr_rec    <= WRW'(T_WR);
                        state     <= S_IDLE;
                    end else begin
                        cmd_q <= CMD_RD;
                        wcnt  <= WCW'(W_RD);
                        ret   <= S_IDLE;
                        state <= S_WAIT;
                    end
                end
                S_REF_PRE: begin
                    if (!any_open) begin
                        state <= S_REF_AR;
                    end else if (wr_rec == '0) begin
                        cmd_q <= CMD_PRE;
                        sd_a  <= A_ALL;
                        wcnt  <= WCW'(W_RP);
                        ret   <= S_REF_AR;
                        state <= S_WAIT;
                    end
                end
                S_REF_AR: begin
                    cmd_q <= CMD_REF;
                    wcnt  <= WCW'(W_RFC);
                    ret   <= S_IDLE;
                    state <= S_WAIT;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sdc_checker.sv
// Protocol checker for sdram_seq_ctrl, attached by bind. Observes pins only.
module sdc_checker #(
    parameter int CAS_LAT = 2,
    parameter int T_RCD   = 2,
    parameter int T_RFC   = 7
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sd_cs_n,
    input logic       sd_ras_n,
    input logic       sd_cas_n,
    input logic       sd_we_n,
    input logic       sd_dq_oe,
    input logic [1:0] sd_dqm,
    input logic       rd_valid
);
    logic [3:0] c;
    logic       is_rd;

    // Gather the command pins into one code.
    always_comb begin
        c     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        is_rd = (c == 4'b0101);
    end

    p_cmd_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        c inside {4'b0000, 4'b0001, 4'b0010, 4'b0011, 4'b0100, 4'b0101, 4'b0111});

    p_write_drive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0100) |-> (sd_dq_oe && sd_dqm == 2'b00));

    p_oe_only_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> (c == 4'b0100));

    p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_rd_after_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(is_rd, CAS_LAT + 1));

    if (T_RCD > 1) begin : g_rcd
        p_act_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (c == 4'b0011) |=> (c == 4'b0111));
    end

    if (T_RFC > 1) begin : g_rfc
        p_ref_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (c == 4'b0001) |=> (c == 4'b0111));
    end

endmodule

bind sdram_seq_ctrl sdc_checker #(
    .CAS_LAT (CAS_LAT),
    .T_RCD   (T_RCD),
    .T_RFC   (T_RFC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_dq_oe (sd_dq_oe),
    .sd_dqm   (sd_dqm),
    .rd_valid (rd_valid)
);

// File: tb/test_sdram_seq_ctrl.sv
// Bench: behavioural memory model with protocol checks, a vector table of
// host accesses, then directed tests for reset, refresh and collisions.
module test_sdram_seq_ctrl;

    localparam int CLK_MHZ  = 100;
    localparam int INIT_US  = 2;
    localparam int INIT_CYC = INIT_US * CLK_MHZ;
    localparam int REFI_CYC = 7800 * CLK_MHZ / 1000;
    localparam int CL       = 2;
    localparam int T_RCD    = 2;
    localparam int T_RP     = 2;
    localparam int T_RFC    = 7;
    localparam int T_WR     = 2;
    localparam int T_MRD    = 2;
    localparam int NVEC     = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_a;
    logic [1:0]  sd_dqm;
    logic [15:0] sd_dq_out;
    logic        sd_dq_oe;
    logic [15:0] sd_dq_in;

    always #5 clk = ~clk;

    sdram_seq_ctrl #(
        .CLK_MHZ (CLK_MHZ), .INIT_US (INIT_US), .REFI_NS (7800), .CAS_LAT (CL),
        .T_RCD (T_RCD), .T_RP (T_RP), .T_RFC (T_RFC), .T_WR (T_WR),
        .T_MRD (T_MRD), .INIT_REFS (2), .DW (16), .BA_W (2), .ROW_W (13), .COL_W (9)
    ) i_sdram_seq_ctrl (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_we (req_we), .req_addr (req_addr), .req_wdata (req_wdata),
        .rd_valid (rd_valid), .rd_data (rd_data), .sd_cs_n (sd_cs_n),
        .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
        .sd_ba (sd_ba), .sd_a (sd_a), .sd_dqm (sd_dqm), .sd_dq_out (sd_dq_out),
        .sd_dq_oe (sd_dq_oe), .sd_dq_in (sd_dq_in)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [15:0] mem [logic [23:0]];
    logic [15:0] mdat [CL];
    bit          bopen [4];
    logic [12:0] brow [4];
    int          act_at [4];
    int          cyc = 0, pre_at = -100, last_wr = -100, last_ref = -1;
    int          last_cmd_ref = -100, lmr_at = -100, read_at = 0;
    int          act_count = 0, rw_count = 0, ref_count = 0, init_refs = 0;
    int          nop_run = 0;
    bit          first_cmd = 1, init_done_m = 0;

    assign sd_dq_in = mdat[CL-1];

    // Memory side: decode the pins on each rising edge and check the protocol.
    always @(posedge clk) begin
        logic [3:0]  c;
        logic [15:0] rdv;
        c   = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        rdv = 16'h0;
        if (rst_n && c != 4'b0111) begin
            if (first_cmd) begin
                first_cmd = 0;
                chk(nop_run >= INIT_CYC, "R2 settle NOP cycles", nop_run, INIT_CYC);
                chk(c == 4'b0010 && sd_a[10], "R2 first command precharge-all", {c, sd_a}, {4'b0010, 13'h400});
            end
            chk(cyc - last_cmd_ref >= T_RFC, "R6 refresh-to-command", cyc - last_cmd_ref, T_RFC);
            chk(cyc - lmr_at >= T_MRD, "R6 mode-load-to-command", cyc - lmr_at, T_MRD);
            case (c)
                4'b0000: begin
                    chk(init_refs >= 2, "R2 refreshes before mode load", init_refs, 2);
                    chk(sd_a == 13'(CL << 4) && sd_ba == 2'b00, "R2 mode word", sd_a, 13'(CL << 4));
                    init_done_m = 1;
                    lmr_at = cyc;
                end
                4'b0001: begin
                    chk(!(bopen[0] || bopen[1] || bopen[2] || bopen[3]), "R9 banks closed at refresh",
                        {bopen[3], bopen[2], bopen[1], bopen[0]}, 0);
                    chk(cyc - pre_at >= T_RP, "R6 precharge-to-refresh", cyc - pre_at, T_RP);
                    if (last_ref >= 0) begin
                        chk(cyc - last_ref <= REFI_CYC, "R8 refresh spacing", cyc - last_ref, REFI_CYC);
                    end
                    if (!init_done_m) init_refs++;
                    else ref_count++;
                    last_ref = cyc;
                    last_cmd_ref = cyc;
                end
                4'b0010: begin
                    chk(cyc - last_wr >= T_WR, "R7 write recovery", cyc - last_wr, T_WR);
                    if (sd_a[10]) begin
                        for (int b = 0; b < 4; b++) bopen[b] = 0;
                    end else begin
                        bopen[sd_ba] = 0;
                    end
                    pre_at = cyc;
                end
                4'b0011: begin
                    chk(!bopen[sd_ba], "R5 activate only a closed bank", bopen[sd_ba], 0);
                    chk(cyc - pre_at >= T_RP, "R6 precharge-to-activate", cyc - pre_at, T_RP);
                    bopen[sd_ba]  = 1;
                    brow[sd_ba]   = sd_a;
                    act_at[sd_ba] = cyc;
                    act_count++;
                end
                4'b0100, 4'b0101: begin
                    chk(bopen[sd_ba], "R4 access to an open bank", bopen[sd_ba], 1);
                    chk(sd_a[10] == 1'b0, "R4 no auto precharge", sd_a[10], 0);
                    chk(cyc - act_at[sd_ba] >= T_RCD, "R6 activate-to-column", cyc - act_at[sd_ba], T_RCD);
                    rw_count++;
                    if (c == 4'b0100) begin
                        chk(sd_dq_oe && sd_dqm == 2'b00, "R11 write drive and mask", {sd_dq_oe, sd_dqm}, 3'b100);
                        mem[{sd_ba, brow[sd_ba], sd_a[8:0]}] = sd_dq_out;
                        last_wr = cyc;
                    end else begin
                        if (mem.exists({sd_ba, brow[sd_ba], sd_a[8:0]}))
                            rdv = mem[{sd_ba, brow[sd_ba], sd_a[8:0]}];
                        read_at = cyc;
                    end
                end
                default: chk(0, "R3 illegal command code", c, 4'b0111);
            endcase
        end else if (rst_n && first_cmd) begin
            nop_run++;
        end
        if (rst_n && c != 4'b0100) begin
            if (sd_dq_oe) chk(0, "R11 bus driven outside write", sd_dq_oe, 0);
        end
        mdat[0] <= rdv;
        for (int i = 1; i < CL; i++) mdat[i] <= mdat[i-1];
        cyc = cyc + 1;
    end

    // ---------------- host side ----------------
    // {we, bank, row, col, data (write value or expected read), expects an activate}
    localparam logic [41:0] VEC [NVEC] = '{
        {1'b1, 2'd0, 13'd5,    9'd1,   16'hA001, 1'b1},
        {1'b0, 2'd0, 13'd5,    9'd1,   16'hA001, 1'b0},
        {1'b1, 2'd0, 13'd5,    9'd2,   16'hB002, 1'b0},
        {1'b1, 2'd1, 13'd7,    9'd3,   16'hC003, 1'b1},
        {1'b0, 2'd0, 13'd5,    9'd2,   16'hB002, 1'b0},
        {1'b1, 2'd0, 13'd9,    9'd4,   16'hD004, 1'b1},
        {1'b0, 2'd0, 13'd5,    9'd1,   16'hA001, 1'b1},
        {1'b0, 2'd1, 13'd7,    9'd3,   16'hC003, 1'b0},
        {1'b1, 2'd3, 13'd8191, 9'd511, 16'hE005, 1'b1},
        {1'b0, 2'd3, 13'd8191, 9'd511, 16'hE005, 1'b0},
        {1'b1, 2'd2, 13'd0,    9'd0,   16'hF006, 1'b1},
        {1'b0, 2'd0, 13'd9,    9'd4,   16'hD004, 1'b1},
        {1'b0, 2'd2, 13'd0,    9'd0,   16'hF006, 1'b0},
        {1'b1, 2'd2, 13'd0,    9'd0,   16'h0707, 1'b0},
        {1'b0, 2'd2, 13'd0,    9'd0,   16'h0707, 1'b0}
    };

    // One host access: handshake, wait for its column command / read data, check.
    task automatic do_req(input logic we, input logic [23:0] a, input logic [15:0] d,
                          input bit chk_act, input int exp_act);
        int  a0, rw0, waited;
        bit  seen;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        a0  = act_count;
        rw0 = rw_count;
        @(negedge clk);
        req_valid = 1'b0;
        seen = 0;
        for (waited = 0; waited < 40 && !seen; waited++) begin
            if (we ? (rw_count != rw0) : rd_valid) seen = 1;
            else @(negedge clk);
        end
        if (!we) begin
            chk(seen, "R10 read data strobe", seen, 1);
            chk(rd_data == d, "R10 read data value", rd_data, d);
            chk(cyc == read_at + CL + 1, "R10 read latency", cyc - read_at, CL + 1);
            @(negedge clk);
            chk(!rd_valid, "R10 strobe lasts one cycle", rd_valid, 0);
        end else begin
            chk(seen, "R12 write command issued", seen, 1);
        end
        chk(rw_count - rw0 == 1, "R12 one column command per request", rw_count - rw0, 1);
        if (chk_act) chk(act_count - a0 == exp_act, "R5 activate count", act_count - a0, exp_act);
    endtask

    initial begin
        #(2_000_000);
        chk(0, "watchdog expired", cyc, 0);
        finish_run();
    end

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 NOP in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(!req_ready && !rd_valid, "R1 ready and strobe low in reset", {req_ready, rd_valid}, 0);
        rst_n = 1'b1;
        repeat (INIT_CYC / 2) @(negedge clk);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !req_ready,
            "R1 NOP and not ready while settling", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, req_ready}, 5'b01110);
        while (!req_ready) @(negedge clk);
        chk(init_done_m, "R2 mode loaded before first ready", init_done_m, 1);

        for (int v = 0; v < NVEC; v++) begin
            do_req(VEC[v][41], VEC[v][40:17], VEC[v][16:1], 1'b1, int'(VEC[v][0]));
        end

        // R9: wait for a refresh while idle, then an old open row must be re-activated.
        r0 = ref_count;
        for (int i = 0; i < 1000 && ref_count == r0; i++) @(negedge clk);
        chk(ref_count > r0, "R8 idle refresh occurs", ref_count - r0, 1);
        do_req(1'b0, {2'd1, 13'd7, 9'd3}, 16'hC003, 1'b1, 1);

        // R8 collision: continuous traffic across refresh deadlines.
        r0 = ref_count;
        for (int i = 0; i < 90; i++) begin
            logic [23:0] a;
            a = {2'(i % 4), 13'(i % 3), 9'(i)};
            do_req(1'b1, a, 16'(16'h5000 + i), 1'b0, 0);
            do_req(1'b0, a, 16'(16'h5000 + i), 1'b0, 0);
        end
        chk(ref_count - r0 >= 1, "R8 refresh under traffic", ref_count - r0, 1);
        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule